// File: doc/BRIEF.md
# Shared-Function General-Purpose Port

This block is an 8-bit general-purpose I/O port whose pins double as outputs of other on-chip functions. Software writes a data register and a direction register over an 8-bit internal bus, each with its own write strobe, and reads back the levels seen on the pins after a two-flop synchronizer. For every pin the block computes the value, output enable and pull-up enable that go to the pad ring.

Pins are not all alike. The two lowest pins are open-drain with no pull-up and hand over to a serial display-data link when that link is enabled. Pins 2 to 6 are push-pull and hand over to a PWM output when their own PWM enable is set. Pin 7 is push-pull and serves either a PWM output or a clamp pulse. It returns to port use only when both of those are off, and the clamp wins when both are on. While a pin serves another function, the port registers keep their contents, and the pin takes them up again once that function is released.

Top module: `shared_port`

## Requirements
- R1: After reset the data and direction registers are 0. No pin drives (pad_oe_o = 0x00), pull-ups are on for pins 2..7 and off for pins 0 and 1 (pad_pu_o = 0xFC), and pad_o = 0x00.
- R2: A cycle with wr_data_i high loads all 8 bits of bus_i into the data register at that clock edge. A cycle with wr_ctrl_i high loads the direction register in the same way. Each strobe leaves the other register unchanged.
- R3: Pins 0 and 1 in port mode with direction bit 1 are open-drain: pad_o is 0 and pad_oe_o is 1 exactly when the data bit is 0. Their pull-up is always off.
- R4: Pins 0 and 1 in port mode with direction bit 0 are inputs with no pull-up (pad_oe_o = 0, pad_pu_o = 0).
- R5: With ddc_en_i = 1, pins 0 and 1 ignore the port registers. Pin k drives low (pad_o = 0, pad_oe_o = 1) when ddc_low_i[k] = 1 and releases when it is 0.
- R6: Pin k in 2..6 with pwm_en_i[k-2] = 1 is a push-pull output carrying pwm_i[k-2], with the pull-up off.
- R7: Pins 2..7 in port mode: pad_o equals the data bit and pad_oe_o equals the direction bit. pad_pu_o is the inverse of the direction bit.
- R8: Pin 7 is a port pin only when both pwm_en_i[5] and clamp_en_i are 0. With clamp_en_i = 1 it drives clamp_i, whatever pwm_en_i[5] is. With only pwm_en_i[5] = 1 it drives pwm_i[5].
- R9: rd_data_o returns pad_i through two flops. A change on pad_i shows on rd_data_o after the second rising clock edge and not after the first.
- R10: Enabling and then disabling an alternate function leaves the data and direction registers unchanged, so the pin resumes its earlier port behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_i | input | 8 | Internal write data bus |
| wr_data_i | input | 1 | Write strobe for the data register |
| wr_ctrl_i | input | 1 | Write strobe for the direction register |
| rd_data_o | output | 8 | Synchronized pin levels |
| ddc_en_i | input | 1 | Hands pins 0 and 1 to the display-data link |
| ddc_low_i | input | 2 | Display-data link drive-low request for pins 0 and 1 |
| pwm_en_i | input | 6 | PWM enable, bit k for pin k+2 |
| pwm_i | input | 6 | PWM values, bit k for pin k+2 |
| clamp_en_i | input | 1 | Hands pin 7 to the clamp pulse |
| clamp_i | input | 1 | Clamp pulse value |
| pad_i | input | 8 | Pin levels from the pads |
| pad_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |
| pad_pu_o | output | 8 | Pad pull-up enables |

## Verification
The case that is hardest to reach from the ports is the hand-back after an alternate function, where a pin must resume the register values that were written before the takeover. The bench first loads registers that differ from the reset values. It then enables every PWM channel with all PWM values at 0, so the pins show a state unlike the register contents. After it releases the PWM enables, it checks that the pads show the old register values again. Pin 7 is driven through all four pairings of its two enables to cover the clamp priority.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  typedef enum logic [0:0] {
    PIN_OPEN_DRAIN = 1'b0,
    PIN_PUSH_PULL  = 1'b1
  } pin_kind_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] bus_i,
  input  logic             wr_data_i,
  input  logic             wr_ctrl_i,
  output logic [WIDTH-1:0] data_o,
  output logic [WIDTH-1:0] dir_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      dir_o  <= '0;
    end else begin
      if (wr_data_i) data_o <= bus_i;
      if (wr_ctrl_i) dir_o  <= bus_i;
    end
  end

  AST_DATA_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_i |=> data_o == $past(bus_i)); // R2
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_data_i |=> $stable(data_o)); // R2
  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl_i |=> $stable(dir_o)); // R10
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  AST_SYNC_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> q_o == $past(stage_q[STAGES-2])); // R9
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_mux_pkg::*;
#(
  parameter pin_kind_e KIND = PIN_PUSH_PULL
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alt_en_i,
  input  logic alt_val_i, // open-drain kind: 1 = drive low
  input  logic dat_i,
  input  logic dir_i,
  output logic out_o,
  output logic oe_o,
  output logic pu_o
);
  if (KIND == PIN_OPEN_DRAIN) begin : g_od
    always_comb begin
      out_o = 1'b0;
      pu_o  = 1'b0;
      oe_o  = alt_en_i ? alt_val_i : (dir_i & ~dat_i);
    end
    AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_o |-> !out_o); // R3
  end else begin : g_pp
    always_comb begin
      if (alt_en_i) begin
        out_o = alt_val_i;
        oe_o  = 1'b1;
        pu_o  = 1'b0;
      end else begin
        out_o = dat_i;
        oe_o  = dir_i;
        pu_o  = ~dir_i;
      end
    end
  end

  AST_PU_INPUT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pu_o |-> !oe_o); // R7
endmodule

// File: rtl/shared_port.sv
module shared_port
  import gpio_mux_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int OD_PINS     = 2,
  parameter int SYNC_STAGES = 2,
  localparam int ALT_W      = WIDTH - OD_PINS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WIDTH-1:0]   bus_i,
  input  logic               wr_data_i,
  input  logic               wr_ctrl_i,
  output logic [WIDTH-1:0]   rd_data_o,
  input  logic               ddc_en_i,
  input  logic [OD_PINS-1:0] ddc_low_i,
  input  logic [ALT_W-1:0]   pwm_en_i,
  input  logic [ALT_W-1:0]   pwm_i,
  input  logic               clamp_en_i,
  input  logic               clamp_i,
  input  logic [WIDTH-1:0]   pad_i,
  output logic [WIDTH-1:0]   pad_o,
  output logic [WIDTH-1:0]   pad_oe_o,
  output logic [WIDTH-1:0]   pad_pu_o
);
  logic [WIDTH-1:0] data_q, dir_q;

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i, .rst_ni, .bus_i, .wr_data_i, .wr_ctrl_i,
    .data_o(data_q), .dir_o(dir_q)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(rd_data_o)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic alt_en, alt_val;
    if (i < OD_PINS) begin : g_ddc
      assign alt_en  = ddc_en_i;
      assign alt_val = ddc_low_i[i];
    end else if (i == WIDTH-1) begin : g_dual
      // clamp pulse outranks PWM on the top pin
      assign alt_en  = pwm_en_i[i-OD_PINS] | clamp_en_i;
      assign alt_val = clamp_en_i ? clamp_i : pwm_i[i-OD_PINS];
    end else begin : g_pwm
      assign alt_en  = pwm_en_i[i-OD_PINS];
      assign alt_val = pwm_i[i-OD_PINS];
    end

    gpio_pin_cell #(
      .KIND((i < OD_PINS) ? PIN_OPEN_DRAIN : PIN_PUSH_PULL)
    ) u_cell (
      .clk_i, .rst_ni,
      .alt_en_i(alt_en), .alt_val_i(alt_val),
      .dat_i(data_q[i]), .dir_i(dir_q[i]),
      .out_o(pad_o[i]), .oe_o(pad_oe_o[i]), .pu_o(pad_pu_o[i])
    );
  end

  AST_CLAMP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_en_i |-> (pad_o[WIDTH-1] == clamp_i) && pad_oe_o[WIDTH-1]); // R8
  AST_DDC_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ddc_en_i |-> pad_oe_o[OD_PINS-1:0] == ddc_low_i); // R5
endmodule

// File: tb/shared_port_tb_top.sv
module shared_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus = '0;
  logic       wr_data = 1'b0, wr_ctrl = 1'b0;
  logic [7:0] rd_data;
  logic       ddc_en = 1'b0;
  logic [1:0] ddc_low = '0;
  logic [5:0] pwm_en = '0, pwm = '0;
  logic       clamp_en = 1'b0, clamp = 1'b0;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe, pad_pu;
  int n_tests = 0, n_fail = 0;

  always #2ns clk = ~clk;

  shared_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(bus), .wr_data_i(wr_data), .wr_ctrl_i(wr_ctrl),
    .rd_data_o(rd_data), .ddc_en_i(ddc_en), .ddc_low_i(ddc_low), .pwm_en_i(pwm_en),
    .pwm_i(pwm), .clamp_en_i(clamp_en), .clamp_i(clamp), .pad_i(pad_in),
    .pad_o(pad_out), .pad_oe_o(pad_oe), .pad_pu_o(pad_pu)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_data_reg(input logic [7:0] v);
    @(negedge clk); bus = v; wr_data = 1'b1;
    @(negedge clk); wr_data = 1'b0; bus = 8'h00;
    #1ns;
  endtask

  task automatic wr_ctrl_reg(input logic [7:0] v);
    @(negedge clk); bus = v; wr_ctrl = 1'b1;
    @(negedge clk); wr_ctrl = 1'b0; bus = 8'h00;
    #1ns;
  endtask

  task automatic t_reset();
    check("R1 oe", pad_oe, 8'h00);
    check("R1 pu", pad_pu, 8'hFC);
    check("R1 out", pad_out, 8'h00);
    check("R1 rd", rd_data, 8'h00);
  endtask

  task automatic t_port_mode();
    wr_ctrl_reg(8'hFF);
    wr_data_reg(8'hA5);
    check("R7 out", pad_out, 8'hA4);
    check("R3 oe", pad_oe, 8'hFE);
    check("R3 pu", pad_pu, 8'h00);
    wr_ctrl_reg(8'h0F);
    check("R2 data kept", pad_out, 8'hA4);
    check("R7 oe", pad_oe, 8'h0E);
    check("R7 pu", pad_pu, 8'hF0);
    wr_ctrl_reg(8'hFC);
    check("R4 oe", pad_oe, 8'hFC);
    check("R4 pu", pad_pu, 8'h00);
    wr_data_reg(8'h5A);
    check("R2 ctrl kept", pad_oe, 8'hFC);
    check("R2 new data", pad_out, 8'h58);
  endtask

  task automatic t_ddc();
    wr_ctrl_reg(8'hFF);
    wr_data_reg(8'hA5);
    @(negedge clk); ddc_en = 1'b1; ddc_low = 2'b01; #1ns;
    check("R5 oe low0", pad_oe, 8'hFD);
    check("R5 out", pad_out, 8'hA4);
    ddc_low = 2'b10; #1ns;
    check("R5 oe low1", pad_oe, 8'hFE);
    ddc_en = 1'b0; ddc_low = 2'b00; #1ns;
    check("R10 ddc back", pad_oe, 8'hFE);
  endtask

  task automatic t_pwm();
    wr_ctrl_reg(8'h00);
    wr_data_reg(8'h00);
    @(negedge clk); pwm_en = 6'b011111; pwm = 6'b010101; #1ns;
    check("R6 out", pad_out, 8'h54);
    check("R6 oe", pad_oe, 8'h7C);
    check("R6 pu", pad_pu, 8'h80);
    pwm_en = '0; pwm = '0; #1ns;
  endtask

  task automatic t_pin7();
    @(negedge clk); pwm_en = 6'b100000; pwm = 6'b100000; clamp_en = 1'b0; #1ns;
    check("R8 pwm only", {pad_out[7], pad_oe[7], pad_pu[7]}, 8'h06);
    clamp_en = 1'b1; clamp = 1'b0; #1ns;
    check("R8 clamp wins", {pad_out[7], pad_oe[7], pad_pu[7]}, 8'h02);
    pwm_en = '0; clamp = 1'b1; #1ns;
    check("R8 clamp only", {pad_out[7], pad_oe[7], pad_pu[7]}, 8'h06);
    clamp_en = 1'b0; clamp = 1'b0; pwm = '0; #1ns;
    check("R8 port", {pad_out[7], pad_oe[7], pad_pu[7]}, 8'h01);
  endtask

  task automatic t_handback();
    wr_ctrl_reg(8'hFF);
    wr_data_reg(8'hFF);
    @(negedge clk); pwm_en = 6'b111111; pwm = '0; #1ns;
    check("R10 alt shown", pad_out, 8'h00);
    @(negedge clk); @(negedge clk); pwm_en = '0; #1ns;
    check("R10 out back", pad_out, 8'hFC);
    check("R10 oe back", pad_oe, 8'hFC);
  endtask

  task automatic t_sync();
    @(negedge clk); pad_in = 8'h3C;
    @(negedge clk);
    check("R9 one edge", rd_data, 8'h00);
    @(negedge clk);
    check("R9 two edges", rd_data, 8'h3C);
    pad_in = 8'hC3;
    @(negedge clk); @(negedge clk);
    check("R9 second value", rd_data, 8'hC3);
  endtask

  initial begin
    #200us;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual expired expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1ns;
    t_reset();
    rst_n = 1'b1;
    t_port_mode();
    t_ddc();
    t_pwm();
    t_pin7();
    t_handback();
    t_sync();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule